// File: doc/BRIEF.md
# Line-Frequency Clock

This block is a line-time clock peripheral. A divider of the system clock makes a tick at 50 or 60 per second. Each tick sets a done (monitor) flag and, when interrupts are enabled, raises an interrupt request. Software sees one 16-bit control/status register. It can enable the interrupt and, where the monitor option exists, clear the done flag. An interrupt acknowledge input withdraws the request.

Three build-time switches set the processor variant. The first decides whether the done flag can be read and cleared by software. The second decides whether an acknowledge also clears done. The third removes the register altogether. In that last variant the interrupt is always enabled, and every bus access is answered with a nonexistent-register error. A separate strobe selects the tick rate. Reset brings the rate back to the configured default.

Top module: `line_clock`

## Requirements
- R1: Reset leaves done at 1, interrupt-enable at 0 and the interrupt request low. It restores the tick rate to the DEFAULT_HZ parameter (60 by default) and restarts the divider.
- R2: `line_tick` is a pulse one cycle wide that repeats every SYS_HZ/rate cycles. A `rate_wr` strobe loads the rate (`rate_50` = 1 selects 50, 0 selects 60) and restarts the divider. No other rate exists.
- R3: A tick sets done. It raises `irq` if interrupt-enable is 1 or the forced-enable mode is active. A tick has priority over a write or acknowledge in the same cycle.
- R4: The register has interrupt-enable at bit 6 and done at bit 7, and every other bit reads 0. Reads are combinational while `bus_rd` is high. Without the monitor option, bit 7 always reads 0.
- R5: An even write loads interrupt-enable from data bit 6. With the monitor option, a 0 in data bit 7 clears done and a 1 has no effect. Without the option, bit 7 is ignored.
- R6: After a write, `irq` is withdrawn if done is 0, or if interrupt-enable is 0 and forced-enable is off. A write never raises `irq`.
- R7: A write with `bus_odd` high (the odd byte) changes nothing.
- R8: `iack` drops `irq`. In the clear-on-acknowledge variant it also clears done. Otherwise done is kept.
- R9: In the register-less variant, `bus_nxm` is high in the same cycle as any read or write, `bus_rdata` is 0, and writes have no effect. Interrupts are forced enabled, so every tick raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_wr | input | 1 | Load the tick rate from `rate_50` and restart the divider |
| rate_50 | input | 1 | 1 selects 50 ticks per second, 0 selects 60 |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_odd | input | 1 | Access targets the odd byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| bus_nxm | output | 1 | Nonexistent-register error for the current access |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| line_tick | output | 1 | Divider tick pulse |

## Verification
Read data and `bus_nxm` depend only on the current state and strobe. The bench raises `bus_rd` (or `bus_wr`) and samples them 1 ns later, before any clock edge.

A write or acknowledge driven at a falling edge takes effect at the next rising edge. The bench therefore checks the result at the falling edge that follows.

`line_tick` is registered, so done and `irq` change one edge after the pulse is first seen. For that reason the bench waits for the pulse at a falling edge and checks one cycle later. Tick spacing is counted in whole cycles between pulses seen at falling edges.

// File: rtl/lclk_pkg.sv
// Shared constants and types for the line-frequency clock.
// Assumes a 16-bit register with enable and done at fixed bit positions.
package lclk_pkg;
    localparam int DATA_W   = 16;
    localparam int IE_BIT   = 6;
    localparam int DONE_BIT = 7;

    typedef enum logic {
        RATE_60 = 1'b0,
        RATE_50 = 1'b1
    } rate_e;
endpackage

// File: rtl/lclk_rate.sv
// Tick-rate selector: holds the chosen line rate (50 or 60 per second).
// Assumes DEFAULT_HZ is 50 or 60; any value other than 50 selects 60.
module lclk_rate
    import lclk_pkg::*;
#(
    parameter int DEFAULT_HZ = 60
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rate_wr,
    input  logic  rate_50,
    output rate_e rate,
    output logic  restart
);
    localparam rate_e RATE_AT_RESET = (DEFAULT_HZ == 50) ? RATE_50 : RATE_60;

    // Rate register: default at reset, loaded by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rate <= RATE_AT_RESET;
        else if (rate_wr) rate <= rate_e'(rate_50);
    end

    // A rate change restarts the divider in the same edge.
    assign restart = rate_wr;
endmodule

// File: rtl/lclk_divider.sv
// Tick divider: emits a one-cycle pulse every SYS_HZ/rate system cycles.
// Assumes SYS_HZ/60 >= 2 so that pulses never merge.
module lclk_divider
    import lclk_pkg::*;
#(
    parameter int SYS_HZ = 50_000_000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  rate_e rate,
    output logic  tick
);
    localparam int P50   = SYS_HZ / 50;
    localparam int P60   = SYS_HZ / 60;
    localparam int CNT_W = $clog2(P50 + 1);
    localparam logic [CNT_W-1:0] LAST50 = CNT_W'(P50 - 1);
    localparam logic [CNT_W-1:0] LAST60 = CNT_W'(P60 - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Terminal count for the selected rate.
    assign last = (rate == RATE_50) ? LAST50 : LAST60;

    // Counter and registered tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == last) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/lclk_csr.sv
// Control/status register and interrupt logic of the line clock.
// Assumes the strobes are single-cycle qualified and mutually exclusive
// between read and write. The variant switches are fixed at build time.
module lclk_csr
    import lclk_pkg::*;
#(
    parameter bit HAS_MONITOR = 1'b1,
    parameter bit CLR_ON_ACK  = 1'b0,
    parameter bit HAS_REG     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_odd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              iack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_nxm,
    output logic              irq,
    output logic              done,
    output logic              ie,
    output logic              force_ie
);
    logic force_nxm;
    logic done_n, ie_n, irq_n;
    logic wr_ok;
    logic vis_done;
    logic [DATA_W-1:0] rd_val;
    logic wdata_unused;

    assign wdata_unused = ^{bus_wdata[DATA_W-1:DONE_BIT+1], bus_wdata[IE_BIT-1:0]};

    // Variant flags: loaded at reset from the register-present switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_ie  <= !HAS_REG;
            force_nxm <= !HAS_REG;
        end
    end

    // A write counts only on the even byte of an existing register.
    assign wr_ok = bus_wr && !bus_odd && !force_nxm;

    // Next state: write, then acknowledge, then tick (highest priority).
    always_comb begin
        ie_n   = ie;
        done_n = done;
        irq_n  = irq;
        if (wr_ok) begin
            ie_n = bus_wdata[IE_BIT];
            if (HAS_MONITOR && !bus_wdata[DONE_BIT]) done_n = 1'b0;
            if (!done_n || (!ie_n && !force_ie))    irq_n  = 1'b0;
        end
        if (iack) begin
            irq_n = 1'b0;
            if (CLR_ON_ACK) done_n = 1'b0;
        end
        if (tick) begin
            done_n = 1'b1;
            if (ie_n || force_ie) irq_n = 1'b1;
        end
    end

    // State registers with the reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            done <= 1'b1;
            irq  <= 1'b0;
        end else begin
            ie   <= ie_n;
            done <= done_n;
            irq  <= irq_n;
        end
    end

    // Done is visible to software only when the monitor option exists.
    generate
        if (HAS_MONITOR) begin : g_mon
            assign vis_done = done;
        end else begin : g_nomon
            assign vis_done = 1'b0;
        end
    endgenerate

    // Read value assembly.
    always_comb begin
        rd_val           = '0;
        rd_val[IE_BIT]   = ie;
        rd_val[DONE_BIT] = vis_done;
    end

    // Bus response: data for a present register, error otherwise.
    assign bus_rdata = (bus_rd && !force_nxm) ? rd_val : '0;
    assign bus_nxm   = (bus_rd || bus_wr) && force_nxm;
endmodule

// File: rtl/line_clock.sv
// Line-frequency clock top: rate selector, tick divider and CSR.
// Assumes SYS_HZ is the frequency of clk and DEFAULT_HZ is 50 or 60.
module line_clock
    import lclk_pkg::*;
#(
    parameter int SYS_HZ      = 50_000_000,
    parameter int DEFAULT_HZ  = 60,
    parameter bit HAS_MONITOR = 1'b1,
    parameter bit CLR_ON_ACK  = 1'b0,
    parameter bit HAS_REG     = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rate_wr,
    input  logic        rate_50,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_odd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_nxm,
    input  logic        iack,
    output logic        irq,
    output logic        line_tick
);
    rate_e rate;
    logic  restart;
    logic  csr_done;
    logic  csr_ie;
    logic  csr_force_ie;

    lclk_rate #(.DEFAULT_HZ(DEFAULT_HZ)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_wr (rate_wr),
        .rate_50 (rate_50),
        .rate    (rate),
        .restart (restart)
    );

    lclk_divider #(.SYS_HZ(SYS_HZ)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .rate    (rate),
        .tick    (line_tick)
    );

    lclk_csr #(
        .HAS_MONITOR (HAS_MONITOR),
        .CLR_ON_ACK  (CLR_ON_ACK),
        .HAS_REG     (HAS_REG)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (line_tick),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_odd   (bus_odd),
        .bus_wdata (bus_wdata),
        .iack      (iack),
        .bus_rdata (bus_rdata),
        .bus_nxm   (bus_nxm),
        .irq       (irq),
        .done      (csr_done),
        .ie        (csr_ie),
        .force_ie  (csr_force_ie)
    );
endmodule

// File: rtl/lclk_checker.sv
// Property checker for the line clock, bound to every line_clock instance.
// Assumes the bound top exposes csr_done, csr_ie and csr_force_ie.
module lclk_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic bus_wr,
    input logic bus_odd,
    input logic bus_nxm,
    input logic iack,
    input logic irq,
    input logic done,
    input logic ie,
    input logic force_ie
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (done && !ie && !irq));

    a_r2_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r3_tick_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> done);

    a_r3_forced_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && force_ie) |=> irq);

    a_r6_irq_only_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    a_r7_odd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_odd && !tick && !iack) |=> ($stable(ie) && $stable(done) && $stable(irq)));

    a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (iack && !tick) |=> !irq);

    a_r9_nxm_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_nxm && !tick && !iack) |=> ($stable(ie) && $stable(done) && $stable(irq)));
endmodule

bind line_clock lclk_checker u_lclk_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (line_tick),
    .bus_wr   (bus_wr),
    .bus_odd  (bus_odd),
    .bus_nxm  (bus_nxm),
    .iack     (iack),
    .irq      (irq),
    .done     (csr_done),
    .ie       (csr_ie),
    .force_ie (csr_force_ie)
);

// File: tb/line_clock_bench.sv
`timescale 1ns/1ps
module line_clock_bench;
    localparam int SYS_HZ = 30000;   // 500 cycles at 60/s, 600 at 50/s
    localparam int P60 = SYS_HZ / 60;
    localparam int P50 = SYS_HZ / 50;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_ACK = 2'd2, OP_TICK = 2'd3;

    typedef struct packed {
        logic [23:0] tag;
        logic [1:0]  op;
        logic        odd;
        logic [15:0] wdata;
        logic [15:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    // Stimulus and expectations for the default variant (monitor, register present).
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{"R1 ", OP_RD,   1'b0, 16'h0000, 16'h0080, 1'b0},
        '{"R5 ", OP_WR,   1'b0, 16'h0040, 16'h0040, 1'b0},
        '{"R3 ", OP_TICK, 1'b0, 16'h0000, 16'h00C0, 1'b1},
        '{"R7 ", OP_WR,   1'b1, 16'h0000, 16'h00C0, 1'b1},
        '{"R5 ", OP_WR,   1'b0, 16'h00C0, 16'h00C0, 1'b1},
        '{"R6 ", OP_WR,   1'b0, 16'h0080, 16'h0080, 1'b0},
        '{"R6 ", OP_WR,   1'b0, 16'h00C0, 16'h00C0, 1'b0},
        '{"R3 ", OP_TICK, 1'b0, 16'h0000, 16'h00C0, 1'b1},
        '{"R8 ", OP_ACK,  1'b0, 16'h0000, 16'h00C0, 1'b0},
        '{"R5 ", OP_WR,   1'b0, 16'h0000, 16'h0000, 1'b0},
        '{"R3 ", OP_TICK, 1'b0, 16'h0000, 16'h0080, 1'b0},
        '{"R4 ", OP_WR,   1'b0, 16'hFF3F, 16'h0000, 1'b0}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, rate_wr = 1'b0, rate_50 = 1'b0;
    logic bus_rd = 1'b0, bus_wr = 1'b0, bus_odd = 1'b0, iack = 1'b0;
    logic [15:0] bus_wdata = '0;

    logic [15:0] rd_m, rd_a, rd_n, rd_z;
    logic nxm_m, nxm_a, nxm_n, nxm_z;
    logic irq_m, irq_a, irq_n, irq_z;
    logic tick_m, tick_a, tick_n, tick_z;

    line_clock #(.SYS_HZ(SYS_HZ)) u_line_clock (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_50(rate_50),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_odd(bus_odd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_m), .bus_nxm(nxm_m), .iack(iack), .irq(irq_m), .line_tick(tick_m));

    line_clock #(.SYS_HZ(SYS_HZ), .CLR_ON_ACK(1'b1)) u_ackclr (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_50(rate_50),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_odd(bus_odd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_a), .bus_nxm(nxm_a), .iack(iack), .irq(irq_a), .line_tick(tick_a));

    line_clock #(.SYS_HZ(SYS_HZ), .HAS_MONITOR(1'b0)) u_nomon (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_50(rate_50),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_odd(bus_odd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_n), .bus_nxm(nxm_n), .iack(iack), .irq(irq_n), .line_tick(tick_n));

    line_clock #(.SYS_HZ(SYS_HZ), .HAS_REG(1'b0)) u_noreg (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_50(rate_50),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_odd(bus_odd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_z), .bus_nxm(nxm_z), .iack(iack), .irq(irq_z), .line_tick(tick_z));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reset_all();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] d, input logic odd);
        bus_wdata = d; bus_odd = odd; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_odd = 1'b0;
    endtask

    task automatic do_ack();
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
    endtask

    task automatic wait_tick();
        while (!tick_m) @(negedge clk);
    endtask

    task automatic do_tick();
        wait_tick();
        @(negedge clk);
    endtask

    // Cycles between two consecutive pulses; also checks the pulse width.
    task automatic measure(output int n);
        wait_tick();
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) chk("R2 pulse one cycle", {31'd0, tick_m}, 32'd0);
        end while (!tick_m);
    endtask

    initial begin
        int iv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Table walk on the default variant.
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:   do_write(VEC[i].wdata, VEC[i].odd);
                OP_ACK:  do_ack();
                OP_TICK: do_tick();
                default: ;
            endcase
            bus_rd = 1'b1; #1;
            chk($sformatf("%s vec %0d rdata", VEC[i].tag, i), {16'd0, rd_m}, {16'd0, VEC[i].exp_rd});
            chk($sformatf("%s vec %0d irq", VEC[i].tag, i), {31'd0, irq_m}, {31'd0, VEC[i].exp_irq});
            chk($sformatf("R9 vec %0d no nxm", i), {31'd0, nxm_m}, 32'd0);
            bus_rd = 1'b0;
        end

        // R1 R4 R9: reset state on every variant.
        @(negedge clk);
        reset_all();
        bus_rd = 1'b1; #1;
        chk("R1 main reset read", {16'd0, rd_m}, 32'h0080);
        chk("R1 ackclr reset read", {16'd0, rd_a}, 32'h0080);
        chk("R4 nomon done hidden", {16'd0, rd_n}, 32'h0000);
        chk("R9 noreg read nxm", {31'd0, nxm_z}, 32'd1);
        chk("R9 noreg read zero", {16'd0, rd_z}, 32'd0);
        chk("R1 irq low", {28'd0, irq_m, irq_a, irq_n, irq_z}, 32'd0);
        bus_rd = 1'b0;

        // R9: write reports error in the same cycle.
        bus_wdata = 16'h0040; bus_wr = 1'b1; #1;
        chk("R9 noreg write nxm", {31'd0, nxm_z}, 32'd1);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b1; #1;
        chk("R5 nomon ie set", {16'd0, rd_n}, 32'h0040);
        bus_rd = 1'b0;

        // R3 R9: tick raises irq everywhere, forced on the register-less one.
        do_tick();
        chk("R3 irq on tick all", {28'd0, irq_m, irq_a, irq_n, irq_z}, 32'hF);
        bus_rd = 1'b1; #1;
        chk("R4 nomon read after tick", {16'd0, rd_n}, 32'h0040);
        bus_rd = 1'b0;

        // R8: acknowledge.
        do_ack();
        chk("R8 irq dropped", {28'd0, irq_m, irq_a, irq_n, irq_z}, 32'd0);
        bus_rd = 1'b1; #1;
        chk("R8 done kept without clear-on-ack", {16'd0, rd_m}, 32'h00C0);
        chk("R8 done cleared by ack", {16'd0, rd_a}, 32'h0040);
        bus_rd = 1'b0;

        // R6 R9: write of zero withdraws irq except where forced.
        do_tick();
        do_write(16'h0000, 1'b0);
        chk("R6 main irq withdrawn", {31'd0, irq_m}, 32'd0);
        chk("R6 nomon irq withdrawn", {31'd0, irq_n}, 32'd0);
        chk("R9 noreg irq held", {31'd0, irq_z}, 32'd1);

        // R2 R1: tick spacing, rate change, reset restores default.
        measure(iv);
        chk("R2 interval at 60", iv, P60);
        rate_50 = 1'b1; rate_wr = 1'b1;
        @(negedge clk);
        rate_wr = 1'b0;
        measure(iv);
        chk("R2 interval at 50", iv, P50);
        @(negedge clk);
        reset_all();
        rate_50 = 1'b0;
        measure(iv);
        chk("R1 default rate restored", iv, P60);

        // R3: tick wins over a same-cycle write that clears done.
        @(negedge clk);
        do_write(16'h0040, 1'b0);
        wait_tick();
        do_write(16'h0040, 1'b0);
        bus_rd = 1'b1; #1;
        chk("R3 tick precedence rdata", {16'd0, rd_m}, 32'h00C0);
        chk("R3 tick precedence irq", {31'd0, irq_m}, 32'd1);
        bus_rd = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule